// File: doc/BRIEF.md
# Fractional 16x16 Multiply Sequencer

This unit multiplies two signed 1.15 fractional operands and returns the 1.31 fractional product, which is the full two's-complement product doubled and kept to 32 bits. Only one 8x8 fractional multiplier is used. It is time-shared across four partial-product steps. Every byte of each operand goes through that multiplier, and each step's doubled 16-bit product is folded into a 32-bit accumulator.

Each step's multiplier takes two mixed-signedness bytes. It returns the doubled product plus the bit that the doubling shifted out. The accumulator uses that bit as a carry for the unsigned step and as a sign borrow for the two mixed steps, so no wide adder or sign-extension network is needed.

A client presents both operands with a one-cycle `start` pulse. It then waits for the one-cycle `done` pulse, after which `result` is valid and holds its value until the next accepted start.

Top module: `fracmul_seq`

## Requirements
- R1: When `done` is high, `result` equals (signed `op_a` x signed `op_b`) shifted left by one, truncated to 32 bits, for the operands captured at the accepted start.
- R2: `done` is high for exactly one cycle. It rises on the eighth clock edge after the edge that accepted `start`.
- R3: A `start` that arrives while a product is in progress is ignored. No extra `done` is produced, and the result reflects only the operands captured earlier.
- R4: The steps run in a fixed order: high(a) x high(b) signed; low(a) x low(b) unsigned; signed high(a) x unsigned low(b); signed high(b) x unsigned low(a). Each step takes one multiply cycle followed by one accumulate cycle.
- R5: The first step writes its doubled product to accumulator bits 31:16 and clears bits 15:0.
- R6: The second step writes its doubled product to bits 15:0. The bit shifted out by the doubling is added at bit 16.
- R7: In the third and fourth steps, the shifted-out bit (the sign of the mixed product) is subtracted at bit 24. The doubled product is added at bits 23:8, with the carry rippling into bits 31:24.
- R8: After synchronous active-high reset, `result` is 0x00000000 and `done` is low.
- R9: While no product is in progress, `result` stays unchanged.
- R10: The operand pair -1.0 x -1.0 (0x8000 x 0x8000) wraps to 0x80000000 rather than saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a product; ignored when busy |
| op_a | input | 16 | Multiplicand, signed 1.15 |
| op_b | input | 16 | Multiplier, signed 1.15 |
| result | output | 32 | Product in signed 1.31, held between products |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The following are checked on every cycle by the assertions:
- the step order and the alternation between multiply and accumulate cycles;
- the single-cycle `done` width and its latency from acceptance;
- the sign of the shifted-out bit in the mixed steps;
- the clearing of the low half on the first step;
- the held result while idle;
- the final value against a direct 32-bit product.

Some behaviour only shows at the ports through the bench's scenarios:
- a carry landing at bit 16 (0x00FF x 0x00FF);
- the borrow in the mixed steps with negative high bytes;
- the wrap of -1.0 x -1.0;
- the ignored mid-run start, which must produce no second `done`.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

    localparam int HALF_W = 8;
    localparam int OPND_W = 2 * HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int ACC_W  = 4 * HALF_W;
    localparam int FULL_W = 2 * HALF_W + 2;
    localparam int LAT_W  = 4;

    typedef enum logic [1:0] {
        STEP_HH = 2'd0,   // signed high(a) x signed high(b)
        STEP_LL = 2'd1,   // unsigned low(a) x unsigned low(b)
        STEP_HL = 2'd2,   // signed high(a) x unsigned low(b)
        STEP_LH = 2'd3    // signed high(b) x unsigned low(a)
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } state_e;

    typedef struct packed {
        logic [HALF_W-1:0] x;
        logic [HALF_W-1:0] y;
        logic              x_sgn;
        logic              y_sgn;
    } mul_req_t;

    typedef struct packed {
        logic              carry;   // bit lost by the doubling
        logic [PROD_W-1:0] frac;    // doubled product, 16 bits
    } mul_rsp_t;

    function automatic mul_req_t pick_operands(step_e s,
                                               logic [OPND_W-1:0] a,
                                               logic [OPND_W-1:0] b);
        mul_req_t r;
        logic [HALF_W-1:0] ah, al, bh, bl;
        ah = a[OPND_W-1:HALF_W];
        al = a[HALF_W-1:0];
        bh = b[OPND_W-1:HALF_W];
        bl = b[HALF_W-1:0];
        unique case (s)
            STEP_HH: r = '{x: ah, y: bh, x_sgn: 1'b1, y_sgn: 1'b1};
            STEP_LL: r = '{x: al, y: bl, x_sgn: 1'b0, y_sgn: 1'b0};
            STEP_HL: r = '{x: ah, y: bl, x_sgn: 1'b1, y_sgn: 1'b0};
            default: r = '{x: bh, y: al, x_sgn: 1'b1, y_sgn: 1'b0};
        endcase
        return r;
    endfunction

    function automatic logic [ACC_W-1:0] accumulate(step_e s,
                                                    logic [ACC_W-1:0] acc,
                                                    mul_rsp_t r);
        logic [ACC_W-1:0] nxt;
        unique case (s)
            STEP_HH: nxt = {r.frac, {PROD_W{1'b0}}};
            STEP_LL: nxt = acc + ACC_W'({r.carry, r.frac});
            default: nxt = (acc - (ACC_W'(r.carry) << (3 * HALF_W)))
                           + (ACC_W'(r.frac) << HALF_W);
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/fracmul_core.sv
module fracmul_core
    import fracmul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mul_req_t req,
    output mul_rsp_t rsp
);
    logic signed [HALF_W:0]   xe, ye;
    logic signed [FULL_W-1:0] full;
    logic        [PROD_W-1:0] raw;

    always_comb begin
        xe   = $signed({req.x_sgn & req.x[HALF_W-1], req.x});
        ye   = $signed({req.y_sgn & req.y[HALF_W-1], req.y});
        full = FULL_W'(xe) * FULL_W'(ye);
        raw  = full[PROD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else if (load) begin
            rsp.carry <= raw[PROD_W-1];
            rsp.frac  <= {raw[PROD_W-2:0], 1'b0};
        end
    end

    // R7: a mixed product with a nonzero unsigned byte takes the sign of the signed byte
    p_mixed_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (load && req.x_sgn && !req.y_sgn && req.y != '0)
        |=> (rsp.carry == $past(req.x[HALF_W-1])));

endmodule

// File: rtl/fracmul_ctrl.sv
module fracmul_ctrl
    import fracmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  accept,
    output logic  busy,
    output logic  mul_load,
    output logic  acc_load,
    output step_e step,
    output logic  done
);
    state_e state;

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && start;
    assign mul_load = (state == ST_MUL);
    assign acc_load = (state == ST_ACC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= STEP_HH;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_MUL;
                    step  <= STEP_HH;
                end
                ST_MUL: state <= ST_ACC;
                ST_ACC: begin
                    if (step == STEP_LH) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_MUL;
                        step  <= step_e'(step + 2'd1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Edge counter for the latency check: 1 after the accepting edge
    logic [LAT_W-1:0] lat;
    always_ff @(posedge clk) begin
        if (rst)                           lat <= '0;
        else if (accept)                   lat <= LAT_W'(1);
        else if (lat != '0 && lat != '1)   lat <= lat + LAT_W'(1);
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == LAT_W'(9)));
    p_mul_then_acc_r4: assert property (@(posedge clk) disable iff (rst)
        mul_load |=> acc_load);
    p_step_order_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_load && step != STEP_LH)
        |=> (mul_load && step == step_e'($past(step) + 2'd1)));
    p_first_step_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mul_load && step == STEP_HH));

endmodule

// File: rtl/fracmul_acc.sv
module fracmul_acc
    import fracmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  step_e            step,
    input  mul_rsp_t         rsp,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (load) acc <= accumulate(step, acc, rsp);
    end

    p_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (load && step == STEP_HH) |=> (acc[PROD_W-1:0] == '0));
    // R6: the low half stays as written because the carry only reaches bit 16
    p_low_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (load && step == STEP_LL) |=> (acc[PROD_W-1:0] == $past(rsp.frac)));

endmodule

// File: rtl/fracmul_seq.sv
module fracmul_seq
    import fracmul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic [31:0] result,
    output logic        done
);
    logic              accept, busy, mul_load, acc_load;
    step_e             step;
    logic [OPND_W-1:0] a_q, b_q;
    mul_req_t          req;
    mul_rsp_t          rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    assign req = pick_operands(step, a_q, b_q);

    fracmul_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .accept   (accept),
        .busy     (busy),
        .mul_load (mul_load),
        .acc_load (acc_load),
        .step     (step),
        .done     (done)
    );

    fracmul_core u_core (
        .clk  (clk),
        .rst  (rst),
        .load (mul_load),
        .req  (req),
        .rsp  (rsp)
    );

    fracmul_acc u_acc (
        .clk  (clk),
        .rst  (rst),
        .load (acc_load),
        .step (step),
        .rsp  (rsp),
        .acc  (result)
    );

    // Direct product of the captured operands
    logic signed [ACC_W-1:0] direct;
    assign direct = ACC_W'($signed(a_q)) * ACC_W'($signed(b_q));

    p_result_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> (result == (direct << 1)));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));
    p_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !done));

endmodule

// File: tb/sim_fracmul_seq.sv
module sim_fracmul_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fracmul_seq u0 (
        .clk(clk), .rst(rst), .start(start),
        .op_a(op_a), .op_b(op_b), .result(result), .done(done)
    );

    function automatic logic [31:0] model(logic [15:0] a, logic [15:0] b);
        logic signed [31:0] p;
        p = 32'($signed(a)) * 32'($signed(b));
        return p << 1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected done", result, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(result == e, "R1 result", result, e);
            end
        end
    end

    // Driver: one product, optional start poke while busy (R3)
    task automatic run(logic [15:0] a, logic [15:0] b, bit poke);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        exp_q.push_back(model(a, b));
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (poke && k == 3) begin
                op_a  = ~a;
                op_b  = a ^ b ^ 16'h1234;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (k == 7) check(done == 1'b0, "R2 done early", 32'(done), 32'h0);
        end
        @(negedge clk);
        check(done == 1'b1, "R2 done latency", 32'(done), 32'h1);
        @(negedge clk);
        check(done == 1'b0, "R2 done width", 32'(done), 32'h0);
    endtask

    initial begin
        logic [15:0] s;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(result == 32'h0, "R8 reset result", result, 32'h0);
        check(done == 1'b0, "R8 reset done", 32'(done), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(result == 32'h0, "R8 after reset", result, 32'h0);

        run(16'h4000, 16'h4000, 0);              // R4: 0.5 x 0.5
        check(result == 32'h2000_0000, "R4 half squared", result, 32'h2000_0000);
        run(16'h00FF, 16'h00FF, 0);              // R6: low x low, carry into bit 16
        check(result == 32'h0001_FC02, "R6 low carry", result, 32'h0001_FC02);
        run(16'h8000, 16'h8000, 0);              // R10: wrap
        check(result == 32'h8000_0000, "R10 wrap", result, 32'h8000_0000);
        run(16'hFF01, 16'h00FF, 0);              // R7: negative high byte, mixed borrow
        check(result == model(16'hFF01, 16'h00FF), "R7 mixed borrow a", result,
              model(16'hFF01, 16'h00FF));
        run(16'h00FF, 16'h80FF, 0);              // R7: borrow from second mixed step
        check(result == model(16'h00FF, 16'h80FF), "R7 mixed borrow b", result,
              model(16'h00FF, 16'h80FF));
        run(16'h0000, 16'h7FFF, 0);              // R5: high step only zero
        check(result == 32'h0, "R5 zero", result, 32'h0);
        run(16'h7FFF, 16'h7FFF, 0);
        run(16'h8000, 16'h7FFF, 0);
        run(16'hFFFF, 16'hFFFF, 0);

        // R9: result held while idle
        held = result;
        repeat (6) @(negedge clk);
        check(result == held, "R9 hold", result, held);

        // R3: start while busy ignored
        run(16'h1357, 16'hC0DE, 1);
        held = model(16'h1357, 16'hC0DE);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) check(1'b0, "R3 extra done", 32'(done), 32'h0);
        end
        check(result == held, "R3 ignored start", result, held);

        // Mixed patterns
        s = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            a = s;
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            b = s ^ 16'h5A5A;
            run(a, b, i % 7 == 3);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule